// File: doc/BRIEF.md
# Store Buffer with Fence Stall Control

This block is an eight-entry, in-order queue placed between the store-retire port of a core and the write port of a coherent data cache. Retired stores enter at the tail. The oldest entry is offered to the cache on every cycle that the buffer holds anything, so the buffer drains as fast as the cache accepts writes. For entries behind the head, the block asks the fill-buffer pool for line ownership ahead of time. It throttles these requests when the pool is busy.

A fence unit handles three ordering operations. None of them speeds up or forces the drain. Each one only holds later issue until every store older than the fence has left the buffer and the invalidation queue has emptied:

- A store-load fence holds loads.
- An atomic holds loads and stores.
- A full fence holds all issue, including non-memory instructions.

Younger loads can take data from the youngest buffered store to the same word. A load that finds only a partial match waits instead.

Top module: `stbuf_fence_top`

## Requirements
- R1: A store is accepted on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low when the buffer holds 8 entries, and also while `st_block` is high.
- R2: When the buffer is not empty, `cwr_valid` is high and `cwr_addr`/`cwr_data`/`cwr_be` carry the oldest store. An entry leaves on a cycle with `cwr_valid` and `cwr_ready` both high. Stores reach the cache in acceptance order, and draining continues while any fence is pending.
- R3: `fence_kind` value 1 (value 0 behaves the same) is a store-load fence. From the cycle after it is accepted until release, `ld_block` is high, `st_block` and `all_block` are low, and no load is forwarded.
- R4: `fence_kind` value 2 is an atomic. While it is pending, `ld_block` and `st_block` are high and `all_block` is low. It is not released before `atomic_done` has been seen high in a cycle after acceptance.
- R5: `fence_kind` value 3 is a full fence. While it is pending, `ld_block`, `st_block` and `all_block` are all high.
- R6: The count of older stores includes those accepted in the same cycle as the fence. Once that count is zero, `inv_empty` is high, and the atomic condition is met, `fence_release` is high for exactly one cycle in the following cycle. In that cycle all blocks are low.
- R7: A pending fence is not released while `inv_empty` is low.
- R8: A load with `ld_valid` high compares against the youngest buffered store with an equal address. If that store has all four byte enables set and `ld_block` is low, `ld_fwd_hit` is high and `ld_fwd_data` equals that store's data.
- R9: `ld_wait` is high for a valid load when `ld_block` is high, or when the youngest matching store has a byte-enable mask other than 4'hF. In the second case `ld_fwd_hit` stays low.
- R10: `rfo_valid` offers the address of the oldest non-head entry whose ownership request has not yet been accepted. The head is never offered, and an entry is offered again only if it was not accepted.
- R11: `rfo_valid` is low whenever `fill_used` is 3 or more.
- R12: `fence_ready` is high only when no fence is in progress. A `fence_start` while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retired store present |
| st_ready | output | 1 | Buffer accepts the store |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| cwr_valid | output | 1 | Cache write request (head entry) |
| cwr_ready | input | 1 | Cache accepts the write |
| cwr_addr | output | 32 | Head address |
| cwr_data | output | 32 | Head data |
| cwr_be | output | 4 | Head byte enables |
| rfo_valid | output | 1 | Ownership prefetch request |
| rfo_ready | input | 1 | Fill-buffer pool takes the request |
| rfo_addr | output | 32 | Line address to own |
| fill_used | input | 3 | Fill-buffer slots in use (0 to 4) |
| inv_empty | input | 1 | Invalidation queue has no pending entry |
| fence_start | input | 1 | Fence, atomic or serialising op begins |
| fence_kind | input | 2 | 0/1 store-load, 2 atomic, 3 full |
| fence_ready | output | 1 | No fence in progress |
| atomic_done | input | 1 | Atomic operation finished |
| fence_release | output | 1 | One-cycle release pulse |
| ld_block | output | 1 | Load issue held |
| st_block | output | 1 | Store issue held |
| all_block | output | 1 | All instruction issue held |
| ld_valid | input | 1 | Younger load probing the buffer |
| ld_addr | input | 32 | Load word address |
| ld_fwd_hit | output | 1 | Load served from the buffer |
| ld_fwd_data | output | 32 | Forwarded data |
| ld_wait | output | 1 | Load must wait |

## Verification
The bench first fills the buffer while the cache is stalled. This shows the refusal at eight entries, prefetch of every non-head entry in age order, youngest-match forwarding, and the partial-mask wait. It then runs one fence of each kind against a buffer that still holds stores, with the cache released partway through. One case holds the invalidation queue non-empty and another delays the atomic completion; these separate release-on-empty from release-on-all-conditions and show which ports each kind blocks. A long random phase follows. It mixes stores, cache back-pressure, fill-pool occupancy, loads over a small address set and fences issued at random. This exposes fences that meet younger stores, drain and prefetch on the same cycle, and throttling at the threshold.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    localparam int SB_AW  = 32;
    localparam int SB_DW  = 32;
    localparam int SB_BEW = SB_DW / 8;

    typedef logic [SB_AW-1:0]  addr_t;
    typedef logic [SB_DW-1:0]  data_t;
    typedef logic [SB_BEW-1:0] be_t;

    typedef struct packed {
        logic  vld;
        addr_t addr;
        data_t data;
        be_t   be;
        logic  rfo_sent;
    } sb_entry_t;

    typedef enum logic [1:0] {
        FK_SLD0 = 2'd0,
        FK_SLD  = 2'd1,
        FK_ATOM = 2'd2,
        FK_FULL = 2'd3
    } fence_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_REL  = 2'd2
    } fence_state_e;

    typedef struct packed {
        logic ld;
        logic st;
        logic all;
    } hold_t;

    function automatic logic covers_word(be_t be);
        return &be;
    endfunction

    function automatic hold_t holds_for(fence_kind_e k);
        hold_t h;
        h.ld  = 1'b1;
        h.st  = (k == FK_ATOM) || (k == FK_FULL);
        h.all = (k == FK_FULL);
        return h;
    endfunction

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  addr_t         push_addr,
    input  data_t         push_data,
    input  be_t           push_be,
    input  logic          pop,
    input  logic          rfo_mark,
    input  logic [PW-1:0] rfo_idx,
    output sb_entry_t     ents [DEPTH],
    output logic [PW-1:0] head,
    output logic [CW-1:0] count
);

    sb_entry_t     mem [DEPTH];
    logic [PW-1:0] tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (push) begin
                mem[tail].vld      <= 1'b1;
                mem[tail].addr     <= push_addr;
                mem[tail].data     <= push_data;
                mem[tail].be       <= push_be;
                mem[tail].rfo_sent <= 1'b0;
                tail               <= tail + PW'(1);
            end
            if (pop) begin
                mem[head].vld <= 1'b0;
                head          <= head + PW'(1);
            end
            if (rfo_mark) begin
                mem[rfo_idx].rfo_sent <= 1'b1;
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ents[i] = mem[i];
        end
    end

endmodule

// File: rtl/stbuf_rfo.sv
module stbuf_rfo
    import stbuf_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int FILL_SLOTS  = 4,
    parameter int PF_THROTTLE = 3,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int FW = $clog2(FILL_SLOTS + 1)
) (
    input  sb_entry_t     ents [DEPTH],
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [FW-1:0] fill_used,
    input  logic          rfo_ready,
    output logic          rfo_valid,
    output addr_t         rfo_addr,
    output logic          rfo_mark,
    output logic [PW-1:0] rfo_idx
);

    logic          found;
    logic [PW-1:0] pos;
    logic          throttled;

    always_comb begin
        found   = 1'b0;
        rfo_idx = '0;
        pos     = '0;
        for (int i = 1; i < DEPTH; i++) begin
            pos = head + PW'(i);
            if (!found && (CW'(i) < count) && !ents[pos].rfo_sent) begin
                found   = 1'b1;
                rfo_idx = pos;
            end
        end
    end

    assign throttled = (fill_used >= FW'(PF_THROTTLE)) || (fill_used >= FW'(FILL_SLOTS));
    assign rfo_valid = found && !throttled;
    assign rfo_addr  = ents[rfo_idx].addr;
    assign rfo_mark  = rfo_valid && rfo_ready;

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t     ents [DEPTH],
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic          ld_valid,
    input  addr_t         ld_addr,
    input  logic          ld_block,
    output logic          ld_fwd_hit,
    output data_t         ld_fwd_data,
    output logic          ld_wait
);

    logic          match;
    logic [PW-1:0] sel;
    logic [PW-1:0] pos;

    always_comb begin
        match = 1'b0;
        sel   = '0;
        pos   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = head + PW'(i);
            if ((CW'(i) < count) && (ents[pos].addr == ld_addr)) begin
                match = 1'b1;
                sel   = pos;
            end
        end
    end

    assign ld_fwd_data = ents[sel].data;
    assign ld_fwd_hit  = ld_valid && !ld_block && match && covers_word(ents[sel].be);
    assign ld_wait     = ld_valid && (ld_block || (match && !covers_word(ents[sel].be)));

endmodule

// File: rtl/stbuf_fence_ctl.sv
module stbuf_fence_ctl
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fence_start,
    input  logic [1:0]    fence_kind,
    input  logic [CW-1:0] count_next,
    input  logic          pop,
    input  logic          inv_empty,
    input  logic          atomic_done,
    output logic          fence_ready,
    output logic          fence_release,
    output logic          ld_block,
    output logic          st_block,
    output logic          all_block
);

    fence_state_e  state;
    fence_kind_e   kind;
    logic [CW-1:0] older;
    logic          atom_seen;
    logic          can_release;
    hold_t         hold;

    assign can_release = (older == '0) && inv_empty && ((kind != FK_ATOM) || atom_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            kind      <= FK_SLD;
            older     <= '0;
            atom_seen <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (fence_start) begin
                        state     <= FS_WAIT;
                        kind      <= fence_kind_e'(fence_kind);
                        older     <= count_next;
                        atom_seen <= 1'b0;
                    end
                end
                FS_WAIT: begin
                    if (can_release) begin
                        state <= FS_REL;
                    end else begin
                        if (older != '0) begin
                            older <= older - CW'(pop);
                        end
                        atom_seen <= atom_seen | atomic_done;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign hold          = holds_for(kind);
    assign fence_ready   = (state == FS_IDLE);
    assign fence_release = (state == FS_REL);
    assign ld_block      = (state == FS_WAIT) && hold.ld;
    assign st_block      = (state == FS_WAIT) && hold.st;
    assign all_block     = (state == FS_WAIT) && hold.all;

endmodule

// File: rtl/stbuf_fence_top.sv
module stbuf_fence_top
    import stbuf_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int FILL_SLOTS  = 4,
    parameter int PF_THROTTLE = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            st_valid,
    output logic                            st_ready,
    input  logic [31:0]                     st_addr,
    input  logic [31:0]                     st_data,
    input  logic [3:0]                      st_be,
    output logic                            cwr_valid,
    input  logic                            cwr_ready,
    output logic [31:0]                     cwr_addr,
    output logic [31:0]                     cwr_data,
    output logic [3:0]                      cwr_be,
    output logic                            rfo_valid,
    input  logic                            rfo_ready,
    output logic [31:0]                     rfo_addr,
    input  logic [$clog2(FILL_SLOTS+1)-1:0] fill_used,
    input  logic                            inv_empty,
    input  logic                            fence_start,
    input  logic [1:0]                      fence_kind,
    output logic                            fence_ready,
    input  logic                            atomic_done,
    output logic                            fence_release,
    output logic                            ld_block,
    output logic                            st_block,
    output logic                            all_block,
    input  logic                            ld_valid,
    input  logic [31:0]                     ld_addr,
    output logic                            ld_fwd_hit,
    output logic [31:0]                     ld_fwd_data,
    output logic                            ld_wait
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    sb_entry_t     ents [DEPTH];
    logic [PW-1:0] head;
    logic [CW-1:0] count;
    logic [CW-1:0] count_next;
    logic          push;
    logic          pop;
    logic          rfo_mark;
    logic [PW-1:0] rfo_idx;

    assign st_ready   = (count != CW'(DEPTH)) && !st_block;
    assign push       = st_valid && st_ready;
    assign cwr_valid  = (count != '0);
    assign pop        = cwr_valid && cwr_ready;
    assign count_next = count + CW'(push) - CW'(pop);
    assign cwr_addr   = ents[head].addr;
    assign cwr_data   = ents[head].data;
    assign cwr_be     = ents[head].be;

    stbuf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .push_be   (st_be),
        .pop       (pop),
        .rfo_mark  (rfo_mark),
        .rfo_idx   (rfo_idx),
        .ents      (ents),
        .head      (head),
        .count     (count)
    );

    stbuf_rfo #(
        .DEPTH       (DEPTH),
        .FILL_SLOTS  (FILL_SLOTS),
        .PF_THROTTLE (PF_THROTTLE)
    ) u_rfo (
        .ents      (ents),
        .head      (head),
        .count     (count),
        .fill_used (fill_used),
        .rfo_ready (rfo_ready),
        .rfo_valid (rfo_valid),
        .rfo_addr  (rfo_addr),
        .rfo_mark  (rfo_mark),
        .rfo_idx   (rfo_idx)
    );

    stbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents        (ents),
        .head        (head),
        .count       (count),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_block    (ld_block),
        .ld_fwd_hit  (ld_fwd_hit),
        .ld_fwd_data (ld_fwd_data),
        .ld_wait     (ld_wait)
    );

    stbuf_fence_ctl #(.DEPTH(DEPTH)) u_fence (
        .clk           (clk),
        .rst           (rst),
        .fence_start   (fence_start),
        .fence_kind    (fence_kind),
        .count_next    (count_next),
        .pop           (pop),
        .inv_empty     (inv_empty),
        .atomic_done   (atomic_done),
        .fence_ready   (fence_ready),
        .fence_release (fence_release),
        .ld_block      (ld_block),
        .st_block      (st_block),
        .all_block     (all_block)
    );

endmodule

// File: rtl/stbuf_fence_chk.sv
module stbuf_fence_chk #(
    parameter int FILL_SLOTS  = 4,
    parameter int PF_THROTTLE = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            st_ready,
    input logic                            cwr_valid,
    input logic                            cwr_ready,
    input logic [31:0]                     cwr_addr,
    input logic [31:0]                     cwr_data,
    input logic [3:0]                      cwr_be,
    input logic                            rfo_valid,
    input logic [$clog2(FILL_SLOTS+1)-1:0] fill_used,
    input logic                            inv_empty,
    input logic                            fence_ready,
    input logic                            fence_release,
    input logic                            ld_block,
    input logic                            st_block,
    input logic                            all_block,
    input logic                            ld_fwd_hit
);

    assert_store_refused_R1: assert property (@(posedge clk) disable iff (rst)
        st_block |-> !st_ready);

    assert_head_held_R2: assert property (@(posedge clk) disable iff (rst)
        cwr_valid && !cwr_ready |=> cwr_valid && $stable(cwr_addr) && $stable(cwr_data) && $stable(cwr_be));

    assert_no_fwd_under_fence_R3: assert property (@(posedge clk) disable iff (rst)
        ld_block |-> !ld_fwd_hit);

    assert_atomic_holds_loads_R4: assert property (@(posedge clk) disable iff (rst)
        st_block |-> ld_block);

    assert_full_holds_all_R5: assert property (@(posedge clk) disable iff (rst)
        all_block |-> st_block && ld_block);

    assert_release_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fence_release |=> !fence_release && fence_ready);

    assert_inv_blocks_release_R7: assert property (@(posedge clk) disable iff (rst)
        ld_block && !inv_empty |=> !fence_release);

    assert_rfo_throttle_R11: assert property (@(posedge clk) disable iff (rst)
        (fill_used >= ($clog2(FILL_SLOTS+1))'(PF_THROTTLE)) |-> !rfo_valid);

    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (rst)
        fence_ready |-> !ld_block && !fence_release);

endmodule

bind stbuf_fence_top stbuf_fence_chk #(
    .FILL_SLOTS  (FILL_SLOTS),
    .PF_THROTTLE (PF_THROTTLE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_ready      (st_ready),
    .cwr_valid     (cwr_valid),
    .cwr_ready     (cwr_ready),
    .cwr_addr      (cwr_addr),
    .cwr_data      (cwr_data),
    .cwr_be        (cwr_be),
    .rfo_valid     (rfo_valid),
    .fill_used     (fill_used),
    .inv_empty     (inv_empty),
    .fence_ready   (fence_ready),
    .fence_release (fence_release),
    .ld_block      (ld_block),
    .st_block      (st_block),
    .all_block     (all_block),
    .ld_fwd_hit    (ld_fwd_hit)
);

// File: tb/tb_stbuf_fence_top.sv
module tb_stbuf_fence_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, cwr_ready = 0, rfo_ready = 0, inv_empty = 1;
    logic        fence_start = 0, atomic_done = 0, ld_valid = 0;
    logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
    logic [3:0]  st_be = 0;
    logic [1:0]  fence_kind = 0;
    logic [2:0]  fill_used = 0;
    logic        st_ready, cwr_valid, rfo_valid, fence_ready, fence_release;
    logic        ld_block, st_block, all_block, ld_fwd_hit, ld_wait;
    logic [31:0] cwr_addr, cwr_data, rfo_addr, ld_fwd_data;
    logic [3:0]  cwr_be;

    always #5 clk = ~clk;

    stbuf_fence_top dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .cwr_valid(cwr_valid), .cwr_ready(cwr_ready), .cwr_addr(cwr_addr),
        .cwr_data(cwr_data), .cwr_be(cwr_be), .rfo_valid(rfo_valid),
        .rfo_ready(rfo_ready), .rfo_addr(rfo_addr), .fill_used(fill_used),
        .inv_empty(inv_empty), .fence_start(fence_start), .fence_kind(fence_kind),
        .fence_ready(fence_ready), .atomic_done(atomic_done),
        .fence_release(fence_release), .ld_block(ld_block), .st_block(st_block),
        .all_block(all_block), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data), .ld_wait(ld_wait)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic [31:0] qa [16];
    logic [31:0] qd [16];
    logic [3:0]  qb [16];
    logic        qp [16];
    int          qn = 0;
    logic        m_busy = 0, m_rel = 0, m_atom = 0;
    int          m_kind = 1;
    int          m_older = 0;
    int          drained = 0;

    function automatic int youngest_match(input logic [31:0] a);
        int m = -1;
        for (int i = 0; i < qn; i++) if (qa[i] == a) m = i;
        return m;
    endfunction

    function automatic int next_rfo();
        for (int i = 1; i < qn; i++) if (!qp[i]) return i;
        return -1;
    endfunction

    // monitor: samples 2 ns after the falling edge, inputs already settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                logic e_ld, e_st, e_all, e_rdy, e_pf, push, pop, pfire, cond;
                int ridx, m;
                e_ld  = m_busy;
                e_st  = m_busy && (m_kind == 2 || m_kind == 3);
                e_all = m_busy && (m_kind == 3);
                e_rdy = (qn < 8) && !e_st;
                chk(st_ready === e_rdy, "R1 st_ready", st_ready, e_rdy);
                chk(cwr_valid === (qn > 0), "R2 cwr_valid", cwr_valid, qn > 0);
                if (qn > 0) begin
                    chk(cwr_addr === qa[0], "R2 cwr_addr", cwr_addr, qa[0]);
                    chk(cwr_data === qd[0], "R2 cwr_data", cwr_data, qd[0]);
                    chk(cwr_be === qb[0], "R2 cwr_be", cwr_be, qb[0]);
                end
                ridx = next_rfo();
                e_pf = (ridx >= 0) && (fill_used < 3);
                chk(rfo_valid === e_pf, fill_used >= 3 ? "R11 rfo throttle" : "R10 rfo_valid", rfo_valid, e_pf);
                if (e_pf) chk(rfo_addr === qa[ridx], "R10 rfo_addr", rfo_addr, qa[ridx]);
                chk(ld_block === e_ld, "R3 ld_block", ld_block, e_ld);
                chk(st_block === e_st, "R4 st_block", st_block, e_st);
                chk(all_block === e_all, "R5 all_block", all_block, e_all);
                chk(fence_release === m_rel, inv_empty ? "R6 release" : "R7 release", fence_release, m_rel);
                chk(fence_ready === (!m_busy && !m_rel), "R12 fence_ready", fence_ready, !m_busy && !m_rel);
                if (ld_valid) begin
                    logic e_hit, e_wait;
                    m = youngest_match(ld_addr);
                    e_hit  = !e_ld && (m >= 0) && (qb[m] == 4'hF);
                    e_wait = e_ld || ((m >= 0) && (qb[m] != 4'hF));
                    chk(ld_fwd_hit === e_hit, "R8 ld_fwd_hit", ld_fwd_hit, e_hit);
                    if (e_hit) chk(ld_fwd_data === qd[m], "R8 ld_fwd_data", ld_fwd_data, qd[m]);
                    chk(ld_wait === e_wait, "R9 ld_wait", ld_wait, e_wait);
                end
                push  = st_valid && e_rdy;
                pop   = (qn > 0) && cwr_ready;
                pfire = e_pf && rfo_ready;
                // fence model
                if (m_rel) begin
                    m_rel = 0;
                end else if (m_busy) begin
                    cond = (m_older == 0) && inv_empty && (m_kind != 2 || m_atom);
                    if (cond) begin
                        m_busy = 0;
                        m_rel  = 1;
                    end else begin
                        if (m_older > 0 && pop) m_older--;
                        m_atom = m_atom | atomic_done;
                    end
                end else if (fence_start) begin
                    m_busy  = 1;
                    m_kind  = (fence_kind == 0) ? 1 : int'(fence_kind);
                    m_older = qn + int'(push) - int'(pop);
                    m_atom  = 0;
                end
                // queue model
                if (pfire) qp[ridx] = 1;
                if (pop) begin
                    drained++;
                    for (int i = 0; i < 15; i++) begin
                        qa[i] = qa[i+1]; qd[i] = qd[i+1]; qb[i] = qb[i+1]; qp[i] = qp[i+1];
                    end
                    qn--;
                end
                if (push) begin
                    qa[qn] = st_addr; qd[qn] = st_data; qb[qn] = st_be; qp[qn] = 0;
                    qn++;
                end
            end
        end
    end

    task automatic idle_inputs();
        st_valid = 0; fence_start = 0; atomic_done = 0; ld_valid = 0;
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        idle_inputs();
        st_valid = 1; st_addr = a; st_data = d; st_be = b;
    endtask

    task automatic load(input logic [31:0] a);
        @(negedge clk);
        idle_inputs();
        ld_valid = 1; ld_addr = a;
    endtask

    task automatic fence(input logic [1:0] k);
        @(negedge clk);
        idle_inputs();
        fence_start = 1; fence_kind = k;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle_inputs();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state, checked before the first post-reset edge
        #2;
        chk(st_ready === 1'b1, "R1 reset st_ready", st_ready, 1);
        chk(cwr_valid === 1'b0, "R2 reset cwr_valid", cwr_valid, 0);
        chk(fence_ready === 1'b1, "R12 reset fence_ready", fence_ready, 1);

        // fill with the cache stalled, prefetch everything behind the head
        cwr_ready = 0; rfo_ready = 1; fill_used = 0;
        store(32'h100, 32'hA0, 4'hF);
        store(32'h104, 32'hA1, 4'hF);
        store(32'h100, 32'hA2, 4'hF);
        store(32'h108, 32'hA3, 4'h3);
        store(32'h10C, 32'hA4, 4'hF);
        store(32'h110, 32'hA5, 4'hF);
        store(32'h114, 32'hA6, 4'hF);
        store(32'h118, 32'hA7, 4'hF);
        store(32'h11C, 32'hA8, 4'hF);   // ninth: refused (R1)
        store(32'h11C, 32'hA8, 4'hF);
        load(32'h100);                  // youngest full match (R8)
        load(32'h108);                  // partial mask (R9)
        load(32'h200);                  // no match
        wait_cycles(2);

        // store-load fence with invalidations outstanding (R3, R7)
        fill_used = 3;
        fence(2'd1);
        load(32'h104);
        store(32'h120, 32'hB0, 4'hF);
        inv_empty = 0;
        cwr_ready = 1;
        wait_cycles(14);
        chk(fence_release === 1'b0, "R7 held by invalidations", fence_release, 0);
        inv_empty = 1;
        wait_cycles(4);

        // atomic with late completion (R4)
        cwr_ready = 0;
        store(32'h130, 32'hC0, 4'hF);
        store(32'h134, 32'hC1, 4'hF);
        fence(2'd2);
        store(32'h138, 32'hC2, 4'hF);   // refused while atomic pending
        cwr_ready = 1;
        wait_cycles(6);
        @(negedge clk); idle_inputs(); atomic_done = 1;
        wait_cycles(4);

        // full fence (R5) and zero-kind store-load fence
        cwr_ready = 0;
        store(32'h140, 32'hD0, 4'hF);
        fence(2'd3);
        wait_cycles(3);
        cwr_ready = 1;
        wait_cycles(4);
        fence(2'd0);
        wait_cycles(4);

        // constrained random phase
        void'($urandom(32'd2024));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            st_valid    = ($urandom % 2) == 0;
            st_addr     = 32'h40 + 32'(4 * ($urandom % 8));
            st_data     = $urandom;
            st_be       = (($urandom % 2) == 0) ? 4'hF : 4'($urandom % 15 + 1);
            cwr_ready   = ($urandom % 3) != 0;
            rfo_ready   = ($urandom % 2) == 0;
            fill_used   = 3'($urandom % 5);
            inv_empty   = ($urandom % 8) != 0;
            fence_start = ($urandom % 20) == 0;
            fence_kind  = 2'($urandom % 4);
            atomic_done = ($urandom % 8) == 0;
            ld_valid    = ($urandom % 2) == 0;
            ld_addr     = 32'h40 + 32'(4 * ($urandom % 8));
        end
        @(negedge clk);
        idle_inputs();
        cwr_ready = 1; inv_empty = 1; atomic_done = 1;
        wait_cycles(30);
        chk(drained > 20, "R2 drain progress", drained, 21);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule